// File: doc/BRIEF.md
# Register-List Multiple Transfer Sequencer

This block runs the multi-register memory transfers of a small processor core: block load, block store, push and pop. It takes a low-register bitmask of up to eight registers, plus one flag that adds a ninth register: the link register for a push, the program counter for a pop. It then walks the list one register at a time and makes one word access per cycle. Store data comes through a register-file read port. Loaded words go out through a register-file write port. The base or stack-pointer update is written back through that same port when the transfer completes.

Block transfers count upward from the base. Push and pop use a full-descending stack. The lowest-numbered register always sits at the lowest address, so a push first works out its lowest address and then stores upward. A pop that includes the program counter does not write that word to the register file. The word leaves as a branch target with bit 0 cleared, alongside a flag that asks the core to leave its compact instruction state when exchange is enabled and the word's bit 0 is zero.

Memory is assumed to return read data in the cycle after a request. Register read data is assumed to be valid in the same cycle as the read index.

Top module: `regxfer_seq`

## Requirements
- R1: `start` is taken only while the block is idle. A `start` pulse during a running transfer has no effect on that transfer's accesses, register writes, completion or branch outputs.
- R2: For op 00 (block load) and op 01 (block store), accesses begin at `base_val` with its low two bits cleared. They rise by 4 per cycle, one access per cycle, in ascending register order. The first access is in the second cycle after the accepting edge, and `mem_addr[1:0]` is always 0.
- R3: Op 00 loads words into the listed registers. If mask bit `base_idx` is clear, the done cycle writes register `base_idx` with the aligned base plus 4 times the count. If that bit is set, no base write happens, so the loaded word is the last value written to that register.
- R4: Op 01 stores the values read through the register read port (`mem_we`=1). In the done cycle it always writes register `base_idx` with the aligned base plus 4 times the count.
- R5: Op 10 (push) has a count equal to the mask bits plus the extra flag. It stores upward from the aligned SP minus 4 times the count, lowest register first, and the link register (index 14) comes last when the extra flag is set. In the done cycle, register 13 receives the aligned SP minus 4 times the count.
- R6: Op 11 (pop) loads upward from the aligned SP, lowest register first. In the done cycle, register 13 receives the aligned SP plus 4 times the count.
- R7: A pop with the extra flag loads its last word as the program counter. Index 15 is never written to the register file. Instead `br_valid` pulses with `done`, and `br_target` equals that word with bit 0 cleared.
- R8: When `br_valid` is high, `br_exchange` equals `exch_en` (sampled at start) AND NOT bit 0 of the popped program-counter word.
- R9: A transfer with a count of zero raises `done` in the cycle after the accepting edge, with no memory request and no register write.
- R10: The extra flag has no effect on op 00 and op 01.
- R11: A loaded word reaches the register write port two cycles after its request cycle. `done` comes one cycle after the last request cycle for stores and pushes, and three cycles after it for loads and pops.
- R12: Outside a transfer, and after reset, `mem_req`, `rf_we`, `done` and `br_valid` are low. Consecutive request cycles differ in address by exactly 4, and `done` is never high together with `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, taken when idle |
| op | input | 2 | 00 block load, 01 block store, 10 push, 11 pop |
| base_idx | input | LIDX_W | Base register index for block forms |
| base_val | input | XLEN | Base or stack-pointer value |
| reg_mask | input | LIST_W | Low-register list, bit i = register i |
| extra_en | input | 1 | Adds link (push) or program counter (pop) |
| exch_en | input | 1 | Enables state exchange on a popped program counter |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | XLEN | Word-aligned access address |
| mem_wdata | output | XLEN | Write data |
| mem_rdata | input | XLEN | Read data, valid the cycle after the request |
| rf_rd_idx | output | 4 | Register read index |
| rf_rd_data | input | XLEN | Register read data for `rf_rd_idx` |
| rf_we | output | 1 | Register write enable |
| rf_wr_idx | output | 4 | Register write index |
| rf_wr_data | output | XLEN | Register write data |
| done | output | 1 | One-cycle completion pulse |
| br_valid | output | 1 | Popped program counter branch request |
| br_target | output | XLEN | Branch target, bit 0 cleared |
| br_exchange | output | 1 | Request to leave the compact state |

## Verification
The checker watches every cycle for these properties:
- word alignment of every access;
- the +4 step between back-to-back requests;
- `done` never overlapping a request;
- the program-counter index never reaching the register write port;
- a branch appearing only with `done` and an even target.

Other behaviours depend on the list contents and on memory, and only the bench scenarios can show them:
- the writeback value and whether it is suppressed when the base is in the list;
- the push start address and the link-register ordering;
- the exchange decision for odd and even popped words;
- the empty-list completion;
- the ignored mid-transfer start.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

  typedef enum logic [1:0] {
    XOP_LOAD_BLK  = 2'b00,
    XOP_STORE_BLK = 2'b01,
    XOP_PUSH      = 2'b10,
    XOP_POP       = 2'b11
  } xop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_TAIL = 2'b10
  } xstate_e;

  localparam int unsigned REG_IDX_W = 4;
  localparam logic [REG_IDX_W-1:0] SP_IDX = 4'd13;
  localparam logic [REG_IDX_W-1:0] LR_IDX = 4'd14;
  localparam logic [REG_IDX_W-1:0] PC_IDX = 4'd15;

  // Cycles between the last load request and the finishing edge.
  localparam logic [1:0] LOAD_TAIL = 2'd2;

endpackage

// File: rtl/regxfer_lsb_pick.sv
module regxfer_lsb_pick #(
  parameter int unsigned W = 9,
  localparam int unsigned PW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [W-1:0]  low,
  output logic [PW-1:0] pos
);

  // Isolate the lowest set bit with a two's complement mask.
  assign low = vec & (~vec + W'(1));

  // Binary encode the one-hot value, one OR tree per output bit.
  for (genvar b = 0; b < PW; b++) begin : g_enc
    logic [W-1:0] hit;
    for (genvar i = 0; i < W; i++) begin : g_in
      if (((i >> b) & 1) == 1) begin : g_on
        assign hit[i] = low[i];
      end else begin : g_off
        assign hit[i] = 1'b0;
      end
    end
    assign pos[b] = |hit;
  end

endmodule

// File: rtl/regxfer_plan.sv
module regxfer_plan
  import regxfer_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned LIST_W = 8,
  localparam int unsigned LIDX_W = $clog2(LIST_W),
  localparam int unsigned CNT_W  = $clog2(LIST_W + 2)
) (
  input  xop_e                  op,
  input  logic [LIDX_W-1:0]     base_idx,
  input  logic [XLEN-1:0]       base_val,
  input  logic [LIST_W-1:0]     reg_mask,
  input  logic                  extra_en,
  output logic [LIST_W:0]       ext_mask,
  output logic [CNT_W-1:0]      cnt,
  output logic [XLEN-1:0]       first_addr,
  output logic [XLEN-1:0]       final_val,
  output logic                  wb_en,
  output logic [REG_IDX_W-1:0]  wb_idx,
  output logic                  is_store,
  output logic [REG_IDX_W-1:0]  extra_idx
);

  logic            stack_form;
  logic [XLEN-1:0] aligned;
  logic [XLEN-1:0] span;

  assign stack_form = (op == XOP_PUSH) || (op == XOP_POP);
  assign ext_mask   = {extra_en & stack_form, reg_mask};
  assign is_store   = (op == XOP_STORE_BLK) || (op == XOP_PUSH);
  assign extra_idx  = (op == XOP_PUSH) ? LR_IDX : PC_IDX;

  always_comb begin
    cnt = '0;
    for (int i = 0; i <= LIST_W; i++) begin
      cnt = cnt + CNT_W'(ext_mask[i]);
    end
  end

  assign aligned = base_val & ~XLEN'(3);
  assign span    = XLEN'(cnt) << 2;

  always_comb begin
    if (op == XOP_PUSH) begin
      first_addr = aligned - span;
      final_val  = aligned - span;
    end else begin
      first_addr = aligned;
      final_val  = aligned + span;
    end
  end

  assign wb_en  = (cnt != '0) && !((op == XOP_LOAD_BLK) && reg_mask[base_idx]);
  assign wb_idx = stack_form ? SP_IDX : REG_IDX_W'(base_idx);

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
  import regxfer_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned LIST_W = 8,
  localparam int unsigned LIDX_W = $clog2(LIST_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [1:0]            op,
  input  logic [LIDX_W-1:0]     base_idx,
  input  logic [XLEN-1:0]       base_val,
  input  logic [LIST_W-1:0]     reg_mask,
  input  logic                  extra_en,
  input  logic                  exch_en,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [XLEN-1:0]       mem_addr,
  output logic [XLEN-1:0]       mem_wdata,
  input  logic [XLEN-1:0]       mem_rdata,
  output logic [3:0]            rf_rd_idx,
  input  logic [XLEN-1:0]       rf_rd_data,
  output logic                  rf_we,
  output logic [3:0]            rf_wr_idx,
  output logic [XLEN-1:0]       rf_wr_data,
  output logic                  done,
  output logic                  br_valid,
  output logic [XLEN-1:0]       br_target,
  output logic                  br_exchange
);

  localparam int unsigned PEND_W = LIST_W + 1;
  localparam int unsigned PW     = $clog2(PEND_W);
  localparam int unsigned CNT_W  = $clog2(LIST_W + 2);

  xop_e op_e;
  assign op_e = xop_e'(op);

  // Plan computed from the start inputs.
  logic [PEND_W-1:0]    pl_mask;
  logic [CNT_W-1:0]     pl_cnt;
  logic [XLEN-1:0]      pl_first;
  logic [XLEN-1:0]      pl_final;
  logic                 pl_wb_en;
  logic [REG_IDX_W-1:0] pl_wb_idx;
  logic                 pl_store;
  logic [REG_IDX_W-1:0] pl_xidx;

  regxfer_plan #(.XLEN(XLEN), .LIST_W(LIST_W)) u_plan (
    .op         (op_e),
    .base_idx   (base_idx),
    .base_val   (base_val),
    .reg_mask   (reg_mask),
    .extra_en   (extra_en),
    .ext_mask   (pl_mask),
    .cnt        (pl_cnt),
    .first_addr (pl_first),
    .final_val  (pl_final),
    .wb_en      (pl_wb_en),
    .wb_idx     (pl_wb_idx),
    .is_store   (pl_store),
    .extra_idx  (pl_xidx)
  );

  // Sequencer state.
  xstate_e              state_q;
  logic [PEND_W-1:0]    pend_q;
  logic [XLEN-1:0]      addr_q;
  logic                 store_q;
  logic [REG_IDX_W-1:0] xtra_idx_q;
  logic                 wb_en_q;
  logic [REG_IDX_W-1:0] wb_idx_q;
  logic [XLEN-1:0]      wb_val_q;
  logic                 exch_q;
  logic [1:0]           tail_q;

  // Load return pipeline: request stage, then data stage.
  logic                 ld1_vld_q, ld2_vld_q;
  logic [REG_IDX_W-1:0] ld1_idx_q, ld2_idx_q;
  logic [XLEN-1:0]      pc_q;
  logic                 pc_got_q;

  // Registered outputs.
  logic                 mem_req_q, mem_we_q;
  logic [XLEN-1:0]      mem_addr_q, mem_wdata_q;
  logic                 rf_we_q;
  logic [REG_IDX_W-1:0] rf_wr_idx_q;
  logic [XLEN-1:0]      rf_wr_data_q;
  logic                 done_q, br_valid_q, br_exch_q;
  logic [XLEN-1:0]      br_target_q;

  // Next register to move.
  logic [PEND_W-1:0]    pick_low;
  logic [PW-1:0]        pick_pos;
  logic [PEND_W-1:0]    pend_nxt;
  logic [REG_IDX_W-1:0] cur_idx;

  regxfer_lsb_pick #(.W(PEND_W)) u_pick (
    .vec (pend_q),
    .low (pick_low),
    .pos (pick_pos)
  );

  assign pend_nxt = pend_q & ~pick_low;
  assign cur_idx  = (pick_pos == PW'(LIST_W)) ? xtra_idx_q : REG_IDX_W'(pick_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      pend_q       <= '0;
      addr_q       <= '0;
      store_q      <= 1'b0;
      xtra_idx_q   <= '0;
      wb_en_q      <= 1'b0;
      wb_idx_q     <= '0;
      wb_val_q     <= '0;
      exch_q       <= 1'b0;
      tail_q       <= '0;
      ld1_vld_q    <= 1'b0;
      ld2_vld_q    <= 1'b0;
      ld1_idx_q    <= '0;
      ld2_idx_q    <= '0;
      pc_q         <= '0;
      pc_got_q     <= 1'b0;
      mem_req_q    <= 1'b0;
      mem_we_q     <= 1'b0;
      mem_addr_q   <= '0;
      mem_wdata_q  <= '0;
      rf_we_q      <= 1'b0;
      rf_wr_idx_q  <= '0;
      rf_wr_data_q <= '0;
      done_q       <= 1'b0;
      br_valid_q   <= 1'b0;
      br_exch_q    <= 1'b0;
      br_target_q  <= '0;
    end else begin
      done_q     <= 1'b0;
      br_valid_q <= 1'b0;
      rf_we_q    <= 1'b0;
      ld1_vld_q  <= 1'b0;

      // Read data is valid one cycle after its request.
      ld2_vld_q <= ld1_vld_q;
      ld2_idx_q <= ld1_idx_q;
      if (ld2_vld_q) begin
        if (ld2_idx_q == PC_IDX) begin
          pc_q     <= mem_rdata;
          pc_got_q <= 1'b1;
        end else begin
          rf_we_q      <= 1'b1;
          rf_wr_idx_q  <= ld2_idx_q;
          rf_wr_data_q <= mem_rdata;
        end
      end

      unique case (state_q)
        ST_IDLE: begin
          mem_req_q <= 1'b0;
          mem_we_q  <= 1'b0;
          if (start) begin
            if (pl_cnt == '0) begin
              done_q <= 1'b1;
            end else begin
              state_q    <= ST_RUN;
              pend_q     <= pl_mask;
              addr_q     <= pl_first;
              store_q    <= pl_store;
              xtra_idx_q <= pl_xidx;
              wb_en_q    <= pl_wb_en;
              wb_idx_q   <= pl_wb_idx;
              wb_val_q   <= pl_final;
              exch_q     <= exch_en;
              pc_got_q   <= 1'b0;
            end
          end
        end
        ST_RUN: begin
          mem_req_q   <= 1'b1;
          mem_we_q    <= store_q;
          mem_addr_q  <= addr_q;
          mem_wdata_q <= store_q ? rf_rd_data : '0;
          addr_q      <= addr_q + XLEN'(4);
          pend_q      <= pend_nxt;
          if (!store_q) begin
            ld1_vld_q <= 1'b1;
            ld1_idx_q <= cur_idx;
          end
          if (pend_nxt == '0) begin
            state_q <= ST_TAIL;
            tail_q  <= store_q ? 2'd0 : LOAD_TAIL;
          end
        end
        ST_TAIL: begin
          mem_req_q <= 1'b0;
          mem_we_q  <= 1'b0;
          if (tail_q == 2'd0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            if (wb_en_q) begin
              rf_we_q      <= 1'b1;
              rf_wr_idx_q  <= wb_idx_q;
              rf_wr_data_q <= wb_val_q;
            end
            if (pc_got_q) begin
              br_valid_q  <= 1'b1;
              br_target_q <= {pc_q[XLEN-1:1], 1'b0};
              br_exch_q   <= exch_q & ~pc_q[0];
              pc_got_q    <= 1'b0;
            end
          end else begin
            tail_q <= tail_q - 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req     = mem_req_q;
  assign mem_we      = mem_we_q;
  assign mem_addr    = mem_addr_q;
  assign mem_wdata   = mem_wdata_q;
  assign rf_rd_idx   = cur_idx;
  assign rf_we       = rf_we_q;
  assign rf_wr_idx   = rf_wr_idx_q;
  assign rf_wr_data  = rf_wr_data_q;
  assign done        = done_q;
  assign br_valid    = br_valid_q;
  assign br_target   = br_target_q;
  assign br_exchange = br_exch_q;

endmodule

// File: rtl/regxfer_seq_chk.sv
module regxfer_seq_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req,
  input logic [XLEN-1:0] mem_addr,
  input logic            rf_we,
  input logic [3:0]      rf_wr_idx,
  input logic            done,
  input logic            br_valid,
  input logic [XLEN-1:0] br_target
);

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  assert_addr_step_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + XLEN'(4)));

  assert_done_no_req_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  assert_pc_not_in_rf_R7: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_wr_idx != 4'd15));

  assert_branch_at_done_R7: assert property (@(posedge clk) disable iff (rst)
    br_valid |-> (done && !br_target[0]));

endmodule

bind regxfer_seq regxfer_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .rf_we     (rf_we),
  .rf_wr_idx (rf_wr_idx),
  .done      (done),
  .br_valid  (br_valid),
  .br_target (br_target)
);

// File: tb/test_regxfer_seq.sv
`timescale 1ns/1ps
module test_regxfer_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [2:0]  base_idx = 3'd0;
  logic [31:0] base_val = 32'd0;
  logic [7:0]  reg_mask = 8'd0;
  logic        extra_en = 1'b0;
  logic        exch_en = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        rf_we;
  logic [3:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic        done, br_valid, br_exchange;
  logic [31:0] br_target;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  regxfer_seq i_regxfer_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .base_idx(base_idx),
    .base_val(base_val), .reg_mask(reg_mask), .extra_en(extra_en),
    .exch_en(exch_en), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
    .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .done(done),
    .br_valid(br_valid), .br_target(br_target), .br_exchange(br_exchange)
  );

  function automatic logic [31:0] rf_val(input int i);
    return 32'hA500_0000 | (32'(i) << 8) | 32'(i);
  endfunction

  assign rf_rd_data = rf_val(int'(rf_rd_idx));

  // Memory seen by the design and the model's mirror of it.
  logic [31:0] mem_dut [256];
  logic [31:0] mem_ref [256];

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_dut[i] = 32'hC000_0000 + 32'(i * 3);
      mem_ref[i] = 32'hC000_0000 + 32'(i * 3);
    end
  end

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem_dut[mem_addr[9:2]] <= mem_wdata;
      else        mem_rdata <= mem_dut[mem_addr[9:2]];
    end
  end

  // Expected per-cycle trace, cycle 1 = first cycle after the start edge.
  logic        e_req [16], e_we [16], e_rfwe [16], e_done [16], e_br [16], e_bx [16];
  logic [31:0] e_addr [16], e_wdata [16], e_rfdata [16], e_btgt [16];
  logic [3:0]  e_rfidx [16];
  string       e_tag [16];

  task automatic check_cycle(input int c);
    bit ok;
    ok = (mem_req === e_req[c]) && (rf_we === e_rfwe[c]) &&
         (done === e_done[c]) && (br_valid === e_br[c]);
    if (e_req[c])  ok = ok && (mem_we === e_we[c]) && (mem_addr === e_addr[c]) &&
                        (!e_we[c] || mem_wdata === e_wdata[c]);
    if (e_rfwe[c]) ok = ok && (rf_wr_idx === e_rfidx[c]) && (rf_wr_data === e_rfdata[c]);
    if (e_br[c])   ok = ok && (br_target === e_btgt[c]) && (br_exchange === e_bx[c]);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc %0d got req=%b we=%b a=%h wd=%h rfwe=%b i=%0d d=%h done=%b br=%b t=%h x=%b exp req=%b we=%b a=%h wd=%h rfwe=%b i=%0d d=%h done=%b br=%b t=%h x=%b",
               e_tag[c], c, mem_req, mem_we, mem_addr, mem_wdata, rf_we, rf_wr_idx, rf_wr_data,
               done, br_valid, br_target, br_exchange, e_req[c], e_we[c], e_addr[c], e_wdata[c],
               e_rfwe[c], e_rfidx[c], e_rfdata[c], e_done[c], e_br[c], e_btgt[c], e_bx[c]);
    end
  endtask

  task automatic run_op(input logic [1:0] t_op, input logic [2:0] t_bidx, input logic [31:0] t_base,
                        input logic [7:0] t_mask, input logic t_x, input logic t_ex,
                        input string ovr, input bit poke);
    int items[$];
    int n, last, idx;
    bit is_st, got;
    logic [31:0] abase, a0, fin, d, pcv;
    string acc_tag, fin_tag;
    for (int c = 0; c < 16; c++) begin
      e_req[c] = 0; e_we[c] = 0; e_rfwe[c] = 0; e_done[c] = 0; e_br[c] = 0; e_bx[c] = 0;
      e_addr[c] = 0; e_wdata[c] = 0; e_rfdata[c] = 0; e_btgt[c] = 0; e_rfidx[c] = 0;
      e_tag[c] = "R12";
    end
    for (int i = 0; i < 8; i++) if (t_mask[i]) items.push_back(i);
    if (t_x && t_op[1]) items.push_back(t_op == 2'b10 ? 14 : 15);   // R10: ignored for block forms
    n     = items.size();
    is_st = (t_op == 2'b01) || (t_op == 2'b10);
    abase = t_base & ~32'd3;
    a0    = (t_op == 2'b10) ? abase - 32'(4 * n) : abase;
    fin   = (t_op == 2'b10) ? a0 : abase + 32'(4 * n);
    got   = 0;
    pcv   = 0;
    acc_tag = (t_op == 2'b10) ? "R5" : (t_op == 2'b11) ? "R6" : "R2";
    fin_tag = (t_op == 2'b00) ? "R3" : (t_op == 2'b01) ? "R4" : (t_op == 2'b10) ? "R5" : "R6";
    if (n == 0) begin
      last = 1;
      e_done[1] = 1;
      e_tag[1] = "R9";
    end else begin
      for (int k = 0; k < n; k++) begin
        e_req[k+2]  = 1;
        e_we[k+2]   = is_st;
        e_addr[k+2] = a0 + 32'(4 * k);
        e_tag[k+2]  = acc_tag;
        idx = int'(e_addr[k+2][9:2]);
        if (is_st) begin
          e_wdata[k+2] = rf_val(items[k]);
          mem_ref[idx] = rf_val(items[k]);
        end else begin
          d = mem_ref[idx];
          if (items[k] == 15) begin
            pcv = d; got = 1;
          end else begin
            e_rfwe[k+4] = 1; e_rfidx[k+4] = 4'(items[k]); e_rfdata[k+4] = d;
            e_tag[k+4] = "R11";
          end
        end
      end
      last = is_st ? n + 2 : n + 4;          // R11 completion timing
      e_done[last] = 1;
      e_tag[last]  = fin_tag;
      if (t_op != 2'b00 || !t_mask[t_bidx]) begin
        e_rfwe[last] = 1;
        e_rfidx[last] = t_op[1] ? 4'd13 : {1'b0, t_bidx};
        e_rfdata[last] = fin;
      end
      if (got) begin
        e_br[last] = 1;
        e_btgt[last] = pcv & ~32'd1;
        e_bx[last] = t_ex & ~pcv[0];
        e_tag[last] = "R7 R8";
      end
    end
    if (ovr != "") for (int c = 0; c < 16; c++) e_tag[c] = ovr;

    @(negedge clk);
    op = t_op; base_idx = t_bidx; base_val = t_base; reg_mask = t_mask;
    extra_en = t_x; exch_en = t_ex; start = 1'b1;
    for (int c = 1; c <= last + 2; c++) begin
      @(negedge clk);
      if (c == 1) start = 1'b0;
      check_cycle(c);
      if (poke && c == 2) begin   // R1: a second start while busy
        op = 2'b01; reg_mask = 8'hFF; base_val = 32'h0000_0380; start = 1'b1;
      end
      if (poke && c == 3) start = 1'b0;
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: quiet outputs after reset
    n_chk++;
    if (mem_req !== 0 || rf_we !== 0 || done !== 0 || br_valid !== 0) begin
      n_fail++;
      $display("FAIL R12 reset got req=%b rfwe=%b done=%b br=%b exp 0 0 0 0", mem_req, rf_we, done, br_valid);
    end
    run_op(2'b00, 3'd0, 32'h0000_0200, 8'h00, 1'b0, 1'b0, "", 0);     // R9 empty load
    run_op(2'b10, 3'd0, 32'h0000_0200, 8'h00, 1'b0, 1'b0, "", 0);     // R9 empty push
    run_op(2'b01, 3'd1, 32'h0000_0100, 8'hB5, 1'b0, 1'b0, "", 0);     // R4 store
    run_op(2'b00, 3'd5, 32'h0000_0100, 8'h21, 1'b1, 1'b0, "R10", 0);  // R10 extra ignored
    run_op(2'b00, 3'd3, 32'h0000_0140, 8'h15, 1'b0, 1'b0, "", 0);     // R3 base absent
    run_op(2'b00, 3'd2, 32'h0000_0180, 8'h0C, 1'b0, 1'b0, "", 0);     // R3 base in list
    run_op(2'b10, 3'd0, 32'h0000_0300, 8'h81, 1'b1, 1'b0, "", 0);     // R5 push with link
    run_op(2'b11, 3'd0, 32'h0000_02F4, 8'h81, 1'b1, 1'b1, "", 0);     // R6 R7 R8 even word
    run_op(2'b11, 3'd0, 32'h0000_03C0, 8'h02, 1'b1, 1'b1, "", 0);     // R8 odd word
    run_op(2'b11, 3'd0, 32'h0000_03D0, 8'h00, 1'b1, 1'b0, "", 0);     // R8 exchange disabled
    run_op(2'b00, 3'd0, 32'h0000_0040, 8'hF0, 1'b0, 1'b0, "R1", 1);   // R1 start while busy
    run_op(2'b01, 3'd7, 32'h0000_00C3, 8'h7F, 1'b0, 1'b0, "R2", 0);   // R2 unaligned base
    run_op(2'b10, 3'd0, 32'h0000_0400, 8'hFF, 1'b0, 1'b0, "", 0);     // R5 full list
    run_op(2'b11, 3'd0, 32'h0000_03E0, 8'hFF, 1'b1, 1'b1, "", 0);     // R6 nine words
    run_op(2'b10, 3'd0, 32'h0000_0500, 8'h00, 1'b1, 1'b0, "", 0);     // R5 link only
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hung exp finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule